// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer, with its companion reference divider. A dual-modulus prescaler counts input clock cycles and divides by either P or P+1. Two counters run from the prescaler's terminal count. The 6-bit swallow count A sets how many prescaler cycles use the longer modulus P+1. The 13-bit main count B sets the total number of prescaler cycles in one output period. The resulting division is N = B·P + A input cycles per feedback pulse. The modulus-control signal that steers the prescaler is brought out as a port.

The reference divider takes one-cycle reference strobes, sampled in the same clock domain, and emits one pulse for every R strobes. Either a counter-reset input or a power-down input holds every counter at its load point. Releasing the hold restarts the feedback and reference dividers on the same clock edge, so their outputs start out aligned. Programmed ratios are taken only at a reload, so a new channel never cuts an output period short.

Top module: `psd_divider`

## Requirements
- R1: While no hold is active, `fb_pulse` is high for exactly one clock cycle once every N = B·P + A clock cycles, where B is `main_b`, A is `swallow_a` and P is the base modulus, with A ≤ B and B ≥ 3.
- R2: `presc_sel` selects the base modulus P: 2'b00 gives 8 (8/9), 2'b01 gives 16 (16/17), 2'b10 gives 32 (32/33) and 2'b11 gives 64 (64/65).
- R3: Counting from the cycle after a feedback pulse, `mod_ctl` is high for the first A·(P+1) cycles of the period and low for the rest. With A = 0 it stays low. With A = B it stays high for the whole period.
- R4: A change on `swallow_a`, `main_b` or `presc_sel` has no effect on the period in progress. The new values are taken at the edge that produces the next feedback pulse.
- R5: While `cnt_rst` is high, `fb_pulse` and `ref_pulse` stay low and `mod_ctl` equals (A ≠ 0). After release, the first `fb_pulse` is seen after the N-th rising edge at which every hold is low.
- R6: `pwr_dn` has the same holding effect as `cnt_rst`, with the same restart timing.
- R7: `ref_pulse` is high for one cycle after every R-th rising edge at which `ref_strobe` is high, where R is `ref_div`. An R of 0 acts as 1.
- R8: A change on `ref_div` takes effect at the next reference reload, not within the count in progress.
- R9: After a hold is released, the first `ref_pulse` follows the R-th strobe counted from the release. The reference count therefore starts on the same edge as the feedback count.
- R10: Synchronous active-high `rst` drives `fb_pulse` and `ref_pulse` low and loads every counter, exactly as a hold does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cnt_rst | input | 1 | Holds all counters at their load point |
| pwr_dn | input | 1 | Power-down; holds all counters at their load point |
| presc_sel | input | 2 | Prescaler modulus select |
| swallow_a | input | 6 | Swallow count A |
| main_b | input | 13 | Main count B |
| ref_div | input | 14 | Reference division ratio R |
| ref_strobe | input | 1 | One-cycle marker for each reference input cycle |
| fb_pulse | output | 1 | One pulse per N input cycles, sent to the phase detector |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |
| ref_pulse | output | 1 | One pulse per R reference strobes |

## Verification
The hardest behaviour to reach from the ports is a reprogramming of A, B and the prescaler select in the middle of a period. Only the period after it may change, and the modulus-control boundary has to move with it. The stimulus waits for a feedback pulse and changes all three values a few cycles later. It then measures the next interval, which must still equal the old ratio, and the one after, which must equal the new ratio. The same approach is used to prove that a held counter restarts on the exact edge of release. A hold is applied in mid-count, then released, and the edges are counted until the first feedback and reference pulses appear.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int SEL_W = 2;
    localparam int A_W   = 6;
    localparam int B_W   = 13;
    localparam int R_W   = 14;
    localparam int BASE_MIN_LOG2 = 3;
    localparam int PC_W  = BASE_MIN_LOG2 + (1 << SEL_W);

    typedef enum logic [SEL_W-1:0] {
        PSEL_8  = 2'b00,
        PSEL_16 = 2'b01,
        PSEL_32 = 2'b10,
        PSEL_64 = 2'b11
    } psel_e;

    typedef struct packed {
        logic [A_W-1:0] swallow;
        logic [B_W-1:0] main;
        psel_e          sel;
    } nword_t;

    function automatic logic [PC_W-1:0] base_modulus(input psel_e s);
        return PC_W'(1 << (BASE_MIN_LOG2 + int'(s)));
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int CW = PC_W
) (
    input  logic          clk,
    input  logic          hold,
    input  logic [CW-1:0] base_mod,
    input  logic          use_long,
    output logic          cyc_done
);
    logic [CW-1:0] pcount;
    logic [CW-1:0] modulus;

    always_comb begin
        modulus  = base_mod + CW'(use_long);
        cyc_done = !hold && (pcount == modulus - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (hold || cyc_done) begin
            pcount <= '0;
        end else begin
            pcount <= pcount + CW'(1);
        end
    end
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
    import psd_pkg::*;
#(
    parameter int AW = A_W,
    parameter int BW = B_W
) (
    input  logic          clk,
    input  logic          hold,
    input  logic          cyc_done,
    input  logic [AW-1:0] a_prog,
    input  logic [BW-1:0] b_prog,
    input  psel_e         sel_prog,
    output psel_e         sel_live,
    output logic          use_long,
    output logic          period_pulse
);
    logic [AW-1:0] a_left;
    logic [BW-1:0] b_left;
    logic          last_cycle;

    always_comb begin
        use_long   = (a_left != '0);
        last_cycle = cyc_done && (b_left <= BW'(1));
    end

    always_ff @(posedge clk) begin
        if (hold) begin
            a_left       <= a_prog;
            b_left       <= b_prog;
            sel_live     <= sel_prog;
            period_pulse <= 1'b0;
        end else if (last_cycle) begin
            a_left       <= a_prog;
            b_left       <= b_prog;
            sel_live     <= sel_prog;
            period_pulse <= 1'b1;
        end else begin
            period_pulse <= 1'b0;
            if (cyc_done) begin
                b_left <= b_left - BW'(1);
                if (a_left != '0) begin
                    a_left <= a_left - AW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/psd_refdiv.sv
module psd_refdiv
    import psd_pkg::*;
#(
    parameter int RW = R_W
) (
    input  logic          clk,
    input  logic          hold,
    input  logic          strobe,
    input  logic [RW-1:0] r_prog,
    output logic          ref_out
);
    logic [RW-1:0] r_left;

    always_ff @(posedge clk) begin
        if (hold) begin
            r_left  <= r_prog;
            ref_out <= 1'b0;
        end else if (strobe) begin
            if (r_left <= RW'(1)) begin
                r_left  <= r_prog;
                ref_out <= 1'b1;
            end else begin
                r_left  <= r_left - RW'(1);
                ref_out <= 1'b0;
            end
        end else begin
            ref_out <= 1'b0;
        end
    end
endmodule

// File: rtl/psd_divider.sv
module psd_divider
    import psd_pkg::*;
#(
    parameter int AW = A_W,
    parameter int BW = B_W,
    parameter int RW = R_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_rst,
    input  logic             pwr_dn,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic [AW-1:0]    swallow_a,
    input  logic [BW-1:0]    main_b,
    input  logic [RW-1:0]    ref_div,
    input  logic             ref_strobe,
    output logic             fb_pulse,
    output logic             mod_ctl,
    output logic             ref_pulse
);
    logic            hold;
    logic            cyc_done;
    logic            use_long;
    psel_e           sel_live;
    logic [PC_W-1:0] base_mod;

    assign hold     = rst | cnt_rst | pwr_dn;
    assign base_mod = base_modulus(sel_live);
    assign mod_ctl  = use_long;

    psd_prescaler #(.CW(PC_W)) u_presc (
        .clk      (clk),
        .hold     (hold),
        .base_mod (base_mod),
        .use_long (use_long),
        .cyc_done (cyc_done)
    );

    psd_swallow #(.AW(AW), .BW(BW)) u_swallow (
        .clk          (clk),
        .hold         (hold),
        .cyc_done     (cyc_done),
        .a_prog       (swallow_a),
        .b_prog       (main_b),
        .sel_prog     (psel_e'(presc_sel)),
        .sel_live     (sel_live),
        .use_long     (use_long),
        .period_pulse (fb_pulse)
    );

    psd_refdiv #(.RW(RW)) u_ref (
        .clk     (clk),
        .hold    (hold),
        .strobe  (ref_strobe),
        .r_prog  (ref_div),
        .ref_out (ref_pulse)
    );
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_rst,
    input logic          pwr_dn,
    input logic [AW-1:0] swallow_a,
    input logic          ref_strobe,
    input logic          fb_pulse,
    input logic          mod_ctl,
    input logic          ref_pulse
);
    logic hold;
    assign hold = rst | cnt_rst | pwr_dn;

    // R1: a feedback pulse is never longer than one cycle
    assert_fb_single_R1: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    // R5 and R6: a held divider emits nothing
    assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!fb_pulse && !ref_pulse));

    // R6: while held, the modulus control reflects the loaded swallow count
    assert_hold_mc_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (mod_ctl == ($past(swallow_a) != '0)));

    // R3: in free running, the long modulus only starts with a new period
    assert_mc_rise_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(mod_ctl) && !$past(hold)) |-> fb_pulse);

    // R7: a reference pulse always follows a counted strobe
    assert_ref_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> ($past(ref_strobe) && !$past(hold)));
endmodule

bind psd_divider psd_divider_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_rst    (cnt_rst),
    .pwr_dn     (pwr_dn),
    .swallow_a  (swallow_a),
    .ref_strobe (ref_strobe),
    .fb_pulse   (fb_pulse),
    .mod_ctl    (mod_ctl),
    .ref_pulse  (ref_pulse)
);

// File: tb/psd_divider_bench.sv
module psd_divider_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_rst = 1'b0;
    logic        pwr_dn = 1'b0;
    logic [1:0]  presc_sel = 2'b00;
    logic [5:0]  swallow_a = 6'd3;
    logic [12:0] main_b = 13'd5;
    logic [13:0] ref_div = 14'd4;
    logic        ref_strobe = 1'b0;
    logic        fb_pulse, mod_ctl, ref_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int strobe_every = 0;
    int strobes_seen = 0;
    bit done = 0;

    // behavioural reference state
    int m_ph, m_a, m_b, m_p, r_ph, r_cur;
    bit m_fb, m_ref;

    always #10 clk = ~clk;

    psd_divider u_psd_divider (
        .clk(clk), .rst(rst), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
        .presc_sel(presc_sel), .swallow_a(swallow_a), .main_b(main_b),
        .ref_div(ref_div), .ref_strobe(ref_strobe),
        .fb_pulse(fb_pulse), .mod_ctl(mod_ctl), .ref_pulse(ref_pulse)
    );

    function automatic int pmod(input logic [1:0] s);
        return 8 << s;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic model_step();
        int n, rc;
        if (rst || cnt_rst || pwr_dn) begin
            m_ph = 0; m_a = swallow_a; m_b = main_b; m_p = pmod(presc_sel); m_fb = 0;
            r_ph = 0; r_cur = ref_div; m_ref = 0;
        end else begin
            n = m_b * m_p + m_a;
            if (m_ph == n - 1) begin
                m_fb = 1; m_ph = 0;
                m_a = swallow_a; m_b = main_b; m_p = pmod(presc_sel);
            end else begin
                m_fb = 0; m_ph++;
            end
            m_ref = 0;
            if (ref_strobe) begin
                rc = (r_cur == 0) ? 1 : r_cur;
                if (r_ph == rc - 1) begin
                    m_ref = 1; r_ph = 0; r_cur = ref_div;
                end else begin
                    r_ph++;
                end
            end
        end
    endtask

    task automatic tick();
        cyc++;
        ref_strobe = (strobe_every != 0) && (cyc % strobe_every == 0);
        if (ref_strobe && !(rst || cnt_rst || pwr_dn)) strobes_seen++;
        model_step();
        @(negedge clk);
        check("R1", "fb_pulse", int'(fb_pulse), int'(m_fb));
        check("R3", "mod_ctl", int'(mod_ctl), int'(m_ph < m_a * (m_p + 1)));
        check("R7", "ref_pulse", int'(ref_pulse), int'(m_ref));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // ticks until fb_pulse is seen; returns number of ticks taken
    task automatic wait_fb(output int n);
        n = 0;
        do begin
            tick(); n++;
        end while (!fb_pulse && n < 20000);
    endtask

    task automatic measure(input string req, input int exp_n);
        int n;
        wait_fb(n);
        wait_fb(n);
        check(req, "period", n, exp_n);
    endtask

    initial begin
        int n, mc_hi;
        // R10: reset state
        ticks(3);
        check("R10", "fb_pulse in reset", int'(fb_pulse), 0);
        check("R10", "ref_pulse in reset", int'(ref_pulse), 0);
        check("R10", "mod_ctl in reset", int'(mod_ctl), 1);
        rst = 1'b0;

        // R1, R2: modulus 8, A=3 B=5 -> 43
        measure("R2", 5 * 8 + 3);
        // modulus 16, A=0 B=4 -> 64; mod_ctl never high (R3)
        presc_sel = 2'b01; swallow_a = 6'd0; main_b = 13'd4;
        wait_fb(n);
        mc_hi = 0;
        for (int i = 0; i < 64; i++) begin tick(); if (mod_ctl) mc_hi++; end
        check("R3", "mod_ctl high cycles with A=0", mc_hi, 0);
        measure("R2", 64);
        // modulus 32, A=B=7 -> 231; mod_ctl high all period (R3)
        presc_sel = 2'b10; swallow_a = 6'd7; main_b = 13'd7;
        wait_fb(n); wait_fb(n);
        mc_hi = 0;
        for (int i = 0; i < 231; i++) begin tick(); if (mod_ctl) mc_hi++; end
        check("R3", "mod_ctl high cycles with A=B", mc_hi, 231);
        measure("R1", 231);
        // modulus 64, A=2 B=3 -> 194
        presc_sel = 2'b11; swallow_a = 6'd2; main_b = 13'd3;
        wait_fb(n);
        measure("R2", 194);
        mc_hi = 0;
        for (int i = 0; i < 194; i++) begin tick(); if (mod_ctl) mc_hi++; end
        check("R3", "mod_ctl high cycles A=2 P=64", mc_hi, 2 * 65);

        // R4: mid-period change affects only the following period
        wait_fb(n);
        ticks(5);
        presc_sel = 2'b00; swallow_a = 6'd1; main_b = 13'd6;
        wait_fb(n);
        check("R4", "period after mid change", n + 5, 194);
        wait_fb(n);
        check("R4", "next period uses new values", n, 49);

        // R7, R8, R9: reference divider
        strobe_every = 3;
        ticks(60);
        ref_div = 14'd0;
        ticks(40);
        ref_div = 14'd5;
        ticks(60);

        // R5: counter reset mid-count, then restart alignment
        ticks(7);
        cnt_rst = 1'b1;
        ticks(12);
        check("R5", "fb_pulse held", int'(fb_pulse), 0);
        check("R5", "mod_ctl held", int'(mod_ctl), 1);
        cnt_rst = 1'b0;
        strobes_seen = 0;
        n = 0;
        while (!ref_pulse && n < 1000) begin tick(); n++; end
        check("R9", "strobes to first ref pulse", strobes_seen, 5);
        while (!fb_pulse && n < 1000) begin tick(); n++; end
        check("R5", "edges to first fb pulse", n, 49);

        // R6: power-down
        swallow_a = 6'd4; main_b = 13'd9; presc_sel = 2'b01;
        ticks(11);
        pwr_dn = 1'b1;
        ticks(10);
        check("R6", "fb_pulse in power-down", int'(fb_pulse), 0);
        check("R6", "ref_pulse in power-down", int'(ref_pulse), 0);
        pwr_dn = 1'b0;
        wait_fb(n);
        check("R6", "edges to first fb pulse", n, 9 * 16 + 4);
        // R8: R change mid-count takes effect next reload
        ref_div = 14'd2;
        ticks(80);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(150000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule